// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block collects interrupt requests from a small set of sources and forwards the most urgent one to a processor. Each source has a fixed priority set by a parameter, and a larger number is more urgent. Level 0 stands for the user program. The controller keeps a stack of the priorities of the handlers in service. A request that outranks the handler on top of that stack is signalled at once, so the running handler is nested under the new one. A request of equal or lower priority stays latched until the handlers above it finish. When a handler ends, the held requests are weighed against the level being restored before that level can run again.

The processor takes a signalled request by raising `cpu_ack` while `cpu_irq` is high. It reads the source index on `cpu_vec` and signals the end of the handler on `eoh`. The source being taken gets a one-cycle acknowledge pulse and may then drop its request. A mode input selects sequential handling instead. In that mode nothing is signalled while any handler is active, and held requests wait until the stack is empty. A global enable gates the interrupt output without losing requests.

Top module: `prio_nest_intc`

## Requirements
- R1: After a clock edge with `rst` high, `cpu_irq` is low, `src_ack` is all zero, no request is pending and the current level is 0 (user program).
- R2: A request that is high at a clock edge is latched as pending for its source, so a request lasting a single cycle is still served later. `cpu_irq` can rise in the cycle that follows the latching edge.
- R3: `cpu_vec` carries the index of the pending source with the largest priority value in `SRC_PRIO`, whose field i is bits [4i+3:4i]. Among equal priorities the lowest source index wins.
- R4: With `seq_mode` = 0 and `glb_en` = 1, `cpu_irq` is high exactly when some request is pending and the priority of the winner is strictly greater than the current level. A request with the same priority as the handler in service does not preempt it.
- R5: A clock edge with `cpu_ack` and `cpu_irq` both high clears the winner's pending bit and pushes its priority, which becomes the current level. `src_ack` then holds a single bit set, at the winner's index, for exactly the next cycle.
- R6: `cpu_ack` while `cpu_irq` is low is ignored: no acknowledge pulse, no change to the pending requests and no change to the level.
- R7: `eoh` pops the stack, so the level returns to that of the preempted handler, or to 0 from the outermost one. `eoh` at level 0 is ignored.
- R8: In the cycle after an `eoh`, a held request that outranks the restored level is already signalled on `cpu_irq`.
- R9: With `seq_mode` = 1, `cpu_irq` stays low while any handler is in service. Requests stay pending and are signalled once the stack is empty.
- R10: With `glb_en` = 0, `cpu_irq` stays low, requests are still latched, and they are signalled once `glb_en` returns to 1.
- R11: With sources of priority 2, 4 and 5, the following order results. The priority-2 handler starts and the priority-5 request preempts it. A priority-4 request arriving under it waits, and it is taken as soon as the priority-5 handler ends. Then the priority-2 handler resumes, and after it the user level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| irq_req | input | N_SRC | Request line per source |
| glb_en | input | 1 | Global interrupt enable |
| seq_mode | input | 1 | 0: nested by priority, 1: sequential |
| cpu_ack | input | 1 | Processor accepts the signalled request |
| eoh | input | 1 | Processor finished the current handler |
| cpu_irq | output | 1 | Interrupt request to the processor |
| cpu_vec | output | clog2(N_SRC) | Index of the source being signalled |
| src_ack | output | N_SRC | One-cycle acknowledge pulse per source |

## Verification
The bench runs four sources, with one pair sharing a priority, so that ties and equal-priority blocking can be provoked. Directed sequences cover several cases: the three-level preemption chain, a held request taken the moment its blocker ends, single-cycle pulses, simultaneous requests, stray acknowledges, end-of-handler at the user level, and both enable and mode gating. Each of these separates a correct level comparison from one that is too eager or too strict. A long stretch of random requests, acknowledges, handler ends and mode flips is then compared every cycle against a behavioural queue model. That stretch catches stack depth and restore errors that a short sequence would miss.

// File: rtl/pnic_pkg.sv
package pnic_pkg;

    parameter int PW = 4;

    typedef logic [PW-1:0] prio_t;

    localparam prio_t LEVEL_USER = '0;

    typedef enum logic {
        SVC_NESTED     = 1'b0,
        SVC_SEQUENTIAL = 1'b1
    } svc_mode_e;

    function automatic logic outranks(prio_t cand, prio_t cur);
        return cand > cur;
    endfunction

endpackage

// File: rtl/pnic_pend.sv
module pnic_pend #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);

    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= (pend | req) & ~clr;
    end

    for (genvar g = 0; g < N; g++) begin : g_hold
        // a latched request survives until it is taken
        p_hold_r2: assert property (@(posedge clk) disable iff (rst)
            pend[g] && !clr[g] |=> pend[g]);
    end

endmodule

// File: rtl/pnic_pick.sv
module pnic_pick import pnic_pkg::*; #(
    parameter int N = 3,
    parameter logic [N*PW-1:0] PRIO = {4'd5, 4'd4, 4'd2},
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  pend,
    output logic          hit,
    output logic [IW-1:0] win_idx,
    output prio_t         win_prio
);

    prio_t prio_tab [N];

    for (genvar g = 0; g < N; g++) begin : g_tab
        assign prio_tab[g] = PRIO[g*PW +: PW];
    end

    // scan from the top index down; ">=" lets a lower index take a tie
    always_comb begin
        hit      = 1'b0;
        win_idx  = '0;
        win_prio = LEVEL_USER;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i] && (!hit || !outranks(win_prio, prio_tab[i]))) begin
                hit      = 1'b1;
                win_idx  = IW'(i);
                win_prio = prio_tab[i];
            end
        end
    end

endmodule

// File: rtl/pnic_stack.sv
module pnic_stack import pnic_pkg::*; #(
    parameter int DEPTH = 3,
    localparam int SPW = $clog2(DEPTH + 1),
    localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  push,
    input  prio_t push_prio,
    input  logic  pop,
    output prio_t top_prio,
    output logic  empty
);

    prio_t          slot [DEPTH];
    logic [SPW-1:0] sp;
    logic [SPW-1:0] sp_after_pop;
    logic [AW-1:0]  rd_idx;
    logic           can_push;

    // a pop in the same cycle as a push frees the slot first
    always_comb begin
        sp_after_pop = (pop && sp != '0) ? sp - SPW'(1) : sp;
        can_push     = push && (sp_after_pop < SPW'(DEPTH));
        rd_idx       = AW'(sp - SPW'(1));
    end

    always_ff @(posedge clk) begin
        if (rst)           sp <= '0;
        else if (can_push) sp <= sp_after_pop + SPW'(1);
        else               sp <= sp_after_pop;
    end

    always_ff @(posedge clk) begin
        if (can_push) slot[AW'(sp_after_pop)] <= push_prio;
    end

    assign empty    = (sp == '0);
    assign top_prio = empty ? LEVEL_USER : slot[rd_idx];

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        push && !pop |-> sp < SPW'(DEPTH));

    p_user_eoh_r7: assert property (@(posedge clk) disable iff (rst)
        pop && empty && !push |=> empty);

    p_push_level_r5: assert property (@(posedge clk) disable iff (rst)
        push |=> top_prio == $past(push_prio));

endmodule

// File: rtl/prio_nest_intc.sv
module prio_nest_intc import pnic_pkg::*; #(
    parameter int N_SRC = 3,
    parameter logic [N_SRC*PW-1:0] SRC_PRIO = {4'd5, 4'd4, 4'd2},
    localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] irq_req,
    input  logic             glb_en,
    input  logic             seq_mode,
    input  logic             cpu_ack,
    input  logic             eoh,
    output logic             cpu_irq,
    output logic [IW-1:0]    cpu_vec,
    output logic [N_SRC-1:0] src_ack
);

    logic [N_SRC-1:0] pend;
    logic [N_SRC-1:0] clr;
    logic             hit;
    logic [IW-1:0]    win_idx;
    prio_t            win_prio;
    prio_t            cur_level;
    logic             stk_empty;
    logic             take;
    svc_mode_e        mode;

    assign mode = svc_mode_e'(seq_mode);

    pnic_pend #(.N(N_SRC)) i_pend (
        .clk  (clk),
        .rst  (rst),
        .req  (irq_req),
        .clr  (clr),
        .pend (pend)
    );

    pnic_pick #(.N(N_SRC), .PRIO(SRC_PRIO)) i_pick (
        .pend     (pend),
        .hit      (hit),
        .win_idx  (win_idx),
        .win_prio (win_prio)
    );

    pnic_stack #(.DEPTH(N_SRC)) i_stack (
        .clk       (clk),
        .rst       (rst),
        .push      (take),
        .push_prio (win_prio),
        .pop       (eoh),
        .top_prio  (cur_level),
        .empty     (stk_empty)
    );

    always_comb begin
        cpu_irq = 1'b0;
        if (glb_en && hit) begin
            case (mode)
                SVC_SEQUENTIAL: cpu_irq = stk_empty;
                default:        cpu_irq = outranks(win_prio, cur_level);
            endcase
        end
    end

    assign take    = cpu_ack & cpu_irq;
    assign clr     = take ? (N_SRC'(1) << win_idx) : '0;
    assign cpu_vec = win_idx;

    always_ff @(posedge clk) begin
        if (rst) src_ack <= '0;
        else     src_ack <= clr;
    end

    p_win_pending_r3: assert property (@(posedge clk) disable iff (rst)
        hit |-> pend[win_idx]);

    p_seq_hold_r9: assert property (@(posedge clk) disable iff (rst)
        seq_mode && !stk_empty |-> !cpu_irq);

    p_gate_r10: assert property (@(posedge clk) disable iff (rst)
        !glb_en |-> !cpu_irq);

    p_ack_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        take |=> $onehot(src_ack));

    p_ack_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        !take |=> src_ack == '0);

endmodule

// File: tb/test_prio_nest_intc.sv
module test_prio_nest_intc;

    localparam int CLK_PERIOD = 10;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] irq_req = '0;
    logic         glb_en = 1'b1;
    logic         seq_mode = 1'b0;
    logic         cpu_ack = 1'b0;
    logic         eoh = 1'b0;
    logic         cpu_irq;
    logic [1:0]   cpu_vec;
    logic [N-1:0] src_ack;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // priorities per source: 0 ->2, 1 ->4, 2 ->5, 3 ->4
    int prio_m [N] = '{2, 4, 5, 4};
    bit pend_m [N];
    int stk_m  [$];
    int ack_m  = -1;

    prio_nest_intc #(
        .N_SRC    (N),
        .SRC_PRIO ({4'd4, 4'd5, 4'd4, 4'd2})
    ) i_prio_nest_intc (
        .clk      (clk),
        .rst      (rst),
        .irq_req  (irq_req),
        .glb_en   (glb_en),
        .seq_mode (seq_mode),
        .cpu_ack  (cpu_ack),
        .eoh      (eoh),
        .cpu_irq  (cpu_irq),
        .cpu_vec  (cpu_vec),
        .src_ack  (src_ack)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic void pick_m(output bit h, output int w);
        h = 1'b0;
        w = 0;
        for (int i = 0; i < N; i++)
            if (pend_m[i] && (!h || prio_m[i] > prio_m[w])) begin
                h = 1'b1;
                w = i;
            end
    endfunction

    function automatic bit irq_m();
        bit h;
        int w;
        int cur;
        cur = (stk_m.size() > 0) ? stk_m[$] : 0;
        pick_m(h, w);
        if (!glb_en || !h) return 1'b0;
        if (seq_mode) return stk_m.size() == 0;
        return prio_m[w] > cur;
    endfunction

    // reference model advances on the same edge as the design
    always @(posedge clk) begin
        bit t;
        bit h;
        int w;
        if (rst) begin
            for (int i = 0; i < N; i++) pend_m[i] = 1'b0;
            stk_m.delete();
            ack_m = -1;
        end else begin
            t = cpu_ack && irq_m();
            pick_m(h, w);
            ack_m = t ? w : -1;
            for (int i = 0; i < N; i++) if (irq_req[i]) pend_m[i] = 1'b1;
            if (t) pend_m[w] = 1'b0;
            if (eoh && stk_m.size() > 0) void'(stk_m.pop_back());
            if (t) stk_m.push_back(prio_m[w]);
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        bit e_irq;
        bit h;
        int w;
        int e_ack;
        string tg;
        if (!rst && !done) begin
            e_irq = irq_m();
            pick_m(h, w);
            tg = !glb_en ? "R10" : (seq_mode ? "R9" : "R4");
            chk(cpu_irq === e_irq, tg, int'(cpu_irq), int'(e_irq));
            if (e_irq) chk(cpu_vec === 2'(w), "R3", int'(cpu_vec), w);
            e_ack = (ack_m >= 0) ? (1 << ack_m) : 0;
            chk(src_ack === N'(e_ack), "R5", int'(src_ack), e_ack);
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
        irq_req = irq_req & ~src_ack;
    endtask

    task automatic take(input int v, input string tag);
        chk(cpu_irq === 1'b1, tag, int'(cpu_irq), 1);
        chk(cpu_vec === 2'(v), tag, int'(cpu_vec), v);
        cpu_ack = 1'b1;
        step();
        cpu_ack = 1'b0;
        chk(src_ack === N'(1 << v), "R5", int'(src_ack), 1 << v);
    endtask

    task automatic end_handler();
        eoh = 1'b1;
        step();
        eoh = 1'b0;
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL R11 watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        // R1: reset state
        chk(cpu_irq === 1'b0, "R1", int'(cpu_irq), 0);
        chk(src_ack === '0, "R1", int'(src_ack), 0);
        step();
        chk(cpu_irq === 1'b0, "R1 nothing pending", int'(cpu_irq), 0);

        // R11: worked nesting order
        irq_req[0] = 1'b1; step();
        take(0, "R11 printer starts");
        irq_req[2] = 1'b1; step();
        take(2, "R11 comm preempts");
        irq_req[1] = 1'b1; step(); step();
        chk(cpu_irq === 1'b0, "R11 disk held", int'(cpu_irq), 0);
        end_handler();
        take(1, "R8 disk right after comm");
        end_handler();
        chk(cpu_irq === 1'b0, "R11 printer resumes", int'(cpu_irq), 0);
        irq_req[0] = 1'b1; step();
        chk(cpu_irq === 1'b0, "R4 equal level no preempt", int'(cpu_irq), 0);
        end_handler();
        take(0, "R11 user level reached");
        end_handler();
        chk(cpu_irq === 1'b0, "R7 back at user", int'(cpu_irq), 0);

        // R7: end at user level ignored, then nesting still consistent
        end_handler();
        irq_req[1] = 1'b1; step();
        take(1, "R7 after ignored end");
        irq_req[2] = 1'b1; step();
        take(2, "R7 nest");
        end_handler();
        irq_req[3] = 1'b1; step();
        chk(cpu_irq === 1'b0, "R4 same priority blocked", int'(cpu_irq), 0);
        end_handler();
        take(3, "R7 pop to user");
        end_handler();

        // R3: ties and simultaneous requests
        irq_req[1] = 1'b1; irq_req[3] = 1'b1; step();
        take(1, "R3 tie lowest index");
        end_handler();
        take(3, "R3 tie second");
        end_handler();
        irq_req = '1; step();
        take(2, "R3 highest first");
        chk(cpu_irq === 1'b0, "R4 nothing above 5", int'(cpu_irq), 0);
        end_handler();
        take(1, "R3 next");
        end_handler();
        take(3, "R3 next tie");
        end_handler();
        take(0, "R3 last");
        end_handler();

        // R6: stray acknowledge
        cpu_ack = 1'b1; step(); cpu_ack = 1'b0; step();
        chk(src_ack === '0, "R6 no pulse", int'(src_ack), 0);
        irq_req[0] = 1'b1; step();
        take(0, "R6 level unchanged");
        cpu_ack = 1'b1; step(); cpu_ack = 1'b0;
        irq_req[1] = 1'b1; step();
        take(1, "R6 still nested from 2");
        end_handler();
        end_handler();

        // R2: single-cycle pulse is kept
        irq_req[1] = 1'b1; step();
        irq_req[1] = 1'b0; step(); step();
        take(1, "R2 pulse served");
        end_handler();

        // R10: global enable gating
        glb_en = 1'b0;
        irq_req[2] = 1'b1; step(); step();
        chk(cpu_irq === 1'b0, "R10 gated", int'(cpu_irq), 0);
        glb_en = 1'b1; step();
        take(2, "R10 after enable");
        end_handler();

        // R9: sequential mode
        seq_mode = 1'b1;
        irq_req[0] = 1'b1; step();
        take(0, "R9 first");
        irq_req[2] = 1'b1; step(); step();
        chk(cpu_irq === 1'b0, "R9 waits", int'(cpu_irq), 0);
        end_handler();
        take(2, "R9 after stack empty");
        end_handler();
        seq_mode = 1'b0;

        // random traffic against the model
        for (int c = 0; c < 3000; c++) begin
            if (c % 600 == 300) seq_mode = ~seq_mode;
            glb_en = ($urandom_range(0, 19) != 0);
            for (int i = 0; i < N; i++)
                if ($urandom_range(0, 7) == 0) irq_req[i] = 1'b1;
            cpu_ack = cpu_irq ? ($urandom_range(0, 1) == 1) : ($urandom_range(0, 9) == 0);
            eoh = ($urandom_range(0, 5) == 0);
            step();
        end
        cpu_ack = 1'b0;
        eoh = 1'b0;
        step();

        done = 1'b1;
        summary();
        $finish;
    end

endmodule